// File: doc/BRIEF.md
# Vector Shift-and-Insert Unit

This block carries out the two shift-and-insert operations on a 128-bit vector register. The source vector is cut into lanes and each lane is shifted, either left or right. The bits that the shift vacates in each lane are not cleared. They are filled from the matching bits of the old destination value. A left insert therefore keeps the low destination bits of every lane, and a right insert keeps the high destination bits. No bit crosses a lane boundary, and bits shifted out of a lane are lost.

The lane size code selects 8, 16, 32 or 64-bit lanes. The shift amount arrives already decoded. The width flag limits the operation to the low 64 bits. The scalar flag selects a single 64-bit lane. The result is registered, so it appears one clock after the operands are presented with `valid_i`.

Top module: `shins_unit`

## Requirements
- R1: `lane_sz_i` values 0, 1, 2 and 3 select lane widths of 8, 16, 32 and 64 bits. Lane k occupies bits [k*w +: w]. No bit moves from one lane into another.
- R2: When `dir_right_i`=0, bit p of each lane is source bit p-s of that lane if p >= s, and destination bit p otherwise, where s = `shamt_i`.
- R3: When `dir_right_i`=1, bit p of each lane is source bit p+s of that lane if p+s < w, and destination bit p otherwise. The shift is logical.
- R4: A right insert with s equal to the lane width, including 64 on 64-bit lanes, returns the destination lane unchanged. The shifted source part is zero and does not wrap.
- R5: A left insert with s = 0 returns the source lane unchanged, because the insert mask is empty.
- R6: When `narrow_i`=1, result bits [127:64] are zero and bits [63:0] follow R2/R3.
- R7: When `scalar_i`=1, the operation uses one 64-bit lane at bits [63:0] whatever `lane_sz_i` holds, and bits [127:64] are zero.
- R8: A left shift with s >= w, or a right shift with s > w, returns the destination lane.
- R9: After reset `res_o` and `valid_o` are zero. `res_o` and `valid_o` update one cycle after a cycle with `valid_i`=1. While `valid_i`=0, `res_o` holds its value and `valid_o` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid this cycle |
| src_i | input | 128 | Source vector to shift |
| dst_i | input | 128 | Old destination vector providing the kept bits |
| lane_sz_i | input | 2 | Lane size code (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| shamt_i | input | 7 | Decoded shift amount |
| dir_right_i | input | 1 | 1 selects right insert, 0 selects left insert |
| narrow_i | input | 1 | 64-bit register width, clears the upper half |
| scalar_i | input | 1 | Scalar form, one 64-bit lane |
| res_o | output | 128 | Registered result |
| valid_o | output | 1 | Result valid |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid pipeline and the hold of `res_o` while idle;
- the cleared upper half in the narrow and scalar forms;
- the identity result of a zero left shift;
- the full-lane right shift of a scalar operation returning the old destination.

Correct lane boundaries for each size, the bit-exact placement of shifted and kept bits, and out-of-range shifts can only be shown by the bench. The bench compares every result against a bit-level reference, using directed minimum and maximum shifts per lane size and seeded random operands.

// File: rtl/shins_pkg.sv
package shins_pkg;
  localparam int unsigned VEC_W    = 128;
  localparam int unsigned LANE_MIN = 8;
  localparam int unsigned LANE_MAX = 64;
  localparam int unsigned NUM_SZ   = $clog2(LANE_MAX / LANE_MIN) + 1;
  localparam int unsigned SZ_W     = $clog2(NUM_SZ);
  localparam int unsigned SHAMT_W  = $clog2(LANE_MAX) + 1;

  typedef enum logic [SZ_W-1:0] {
    LSZ_8  = 2'd0,
    LSZ_16 = 2'd1,
    LSZ_32 = 2'd2,
    LSZ_64 = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/shins_mask_gen.sv
module shins_mask_gen
  import shins_pkg::*;
#(
  parameter int unsigned W      = VEC_W,
  parameter int unsigned L_MIN  = LANE_MIN,
  parameter int unsigned N_SZ   = NUM_SZ,
  parameter int unsigned SH_W   = SHAMT_W
) (
  input  lane_sz_e           sz_i,
  input  logic [SH_W-1:0]    shamt_i,
  input  logic               dir_right_i,
  output logic [W-1:0]       keep_o
);
  logic [N_SZ-1:0][W-1:0] keep_by_sz;

  for (genvar s = 0; s < N_SZ; s++) begin : g_sz
    localparam int unsigned ES = L_MIN << s;
    localparam int unsigned NL = W / ES;
    logic [ES-1:0] lane_keep;
    // ones where the shift vacated bits; saturates to all ones past the lane
    assign lane_keep = dir_right_i ? ~({ES{1'b1}} >> shamt_i)
                                   : ~({ES{1'b1}} << shamt_i);
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign keep_by_sz[s][l*ES +: ES] = lane_keep;
    end
  end

  assign keep_o = keep_by_sz[sz_i];
endmodule

// File: rtl/shins_lane_shift.sv
module shins_lane_shift
  import shins_pkg::*;
#(
  parameter int unsigned W      = VEC_W,
  parameter int unsigned L_MIN  = LANE_MIN,
  parameter int unsigned N_SZ   = NUM_SZ,
  parameter int unsigned SH_W   = SHAMT_W
) (
  input  lane_sz_e           sz_i,
  input  logic [SH_W-1:0]    shamt_i,
  input  logic               dir_right_i,
  input  logic [W-1:0]       src_i,
  output logic [W-1:0]       shifted_o
);
  logic [N_SZ-1:0][W-1:0] sh_by_sz;

  for (genvar s = 0; s < N_SZ; s++) begin : g_sz
    localparam int unsigned ES = L_MIN << s;
    localparam int unsigned NL = W / ES;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [ES-1:0] lane;
      assign lane = src_i[l*ES +: ES];
      // logical shift of a full lane width or more yields zero
      assign sh_by_sz[s][l*ES +: ES] = dir_right_i ? (lane >> shamt_i)
                                                   : (lane << shamt_i);
    end
  end

  assign shifted_o = sh_by_sz[sz_i];
endmodule

// File: rtl/shins_unit.sv
module shins_unit
  import shins_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [VEC_W-1:0]    src_i,
  input  logic [VEC_W-1:0]    dst_i,
  input  logic [SZ_W-1:0]     lane_sz_i,
  input  logic [SHAMT_W-1:0]  shamt_i,
  input  logic                dir_right_i,
  input  logic                narrow_i,
  input  logic                scalar_i,
  output logic [VEC_W-1:0]    res_o,
  output logic                valid_o
);
  localparam int unsigned HALF = VEC_W / 2;

  lane_sz_e         eff_sz;
  logic [VEC_W-1:0] keep_mask;
  logic [VEC_W-1:0] shifted;
  logic [VEC_W-1:0] res_c;

  // scalar form is always one widest lane
  assign eff_sz = scalar_i ? LSZ_64 : lane_sz_e'(lane_sz_i);

  shins_mask_gen u_mask (
    .sz_i        (eff_sz),
    .shamt_i     (shamt_i),
    .dir_right_i (dir_right_i),
    .keep_o      (keep_mask)
  );

  shins_lane_shift u_shift (
    .sz_i        (eff_sz),
    .shamt_i     (shamt_i),
    .dir_right_i (dir_right_i),
    .src_i       (src_i),
    .shifted_o   (shifted)
  );

  always_comb begin
    res_c = shifted | (dst_i & keep_mask);
    if (narrow_i || scalar_i) res_c[VEC_W-1:HALF] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_c;
    end
  end
endmodule

// File: rtl/shins_unit_chk.sv
module shins_unit_chk
  import shins_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [VEC_W-1:0]    src_i,
  input logic [VEC_W-1:0]    dst_i,
  input logic [SHAMT_W-1:0]  shamt_i,
  input logic                dir_right_i,
  input logic                narrow_i,
  input logic                scalar_i,
  input logic [VEC_W-1:0]    res_o,
  input logic                valid_o
);
  localparam int unsigned HALF = VEC_W / 2;

  // R9
  valid_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o)));

  // R6
  upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (narrow_i || scalar_i)) |=> (res_o[VEC_W-1:HALF] == '0));

  // R5
  zero_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dir_right_i && shamt_i == '0 && !narrow_i && !scalar_i)
      |=> (res_o == $past(src_i)));

  // R4
  full_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dir_right_i && scalar_i && shamt_i == SHAMT_W'(LANE_MAX))
      |=> (res_o[HALF-1:0] == $past(dst_i[HALF-1:0])));
endmodule

bind shins_unit shins_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .src_i       (src_i),
  .dst_i       (dst_i),
  .shamt_i     (shamt_i),
  .dir_right_i (dir_right_i),
  .narrow_i    (narrow_i),
  .scalar_i    (scalar_i),
  .res_o       (res_o),
  .valid_o     (valid_o)
);

// File: tb/shins_unit_tb_top.sv
module shins_unit_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] src_i = '0;
  logic [127:0] dst_i = '0;
  logic [1:0]   lane_sz_i = '0;
  logic [6:0]   shamt_i = '0;
  logic         dir_right_i = 1'b0;
  logic         narrow_i = 1'b0;
  logic         scalar_i = 1'b0;
  logic [127:0] res_o;
  logic         valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  shins_unit dut_i (.*);

  function automatic logic [127:0] ref_res(logic [127:0] s, logic [127:0] d,
      int sz, int sh, bit dir, bit nar, bit sc);
    int es = sc ? 64 : (8 << sz);
    logic [127:0] r;
    for (int i = 0; i < 128; i++) begin
      int p = i % es;
      if (!dir) begin
        if (p >= sh) r[i] = s[i-sh]; else r[i] = d[i];
      end else begin
        if (p + sh < es) r[i] = s[i+sh]; else r[i] = d[i];
      end
    end
    if (nar || sc) r[127:64] = '0;
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run(logic [127:0] s, logic [127:0] d, int sz, int sh,
      bit dir, bit nar, bit sc, string tag);
    logic [127:0] exp;
    @(negedge clk_i);
    src_i = s; dst_i = d; lane_sz_i = 2'(sz); shamt_i = 7'(sh);
    dir_right_i = dir; narrow_i = nar; scalar_i = sc; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    exp = ref_res(s, d, sz, sh, dir, nar, sc);
    checks++;
    if (res_o !== exp || valid_o !== 1'b1) begin
      errors++;
      $display("FAIL %s sz=%0d sh=%0d dir=%0d: res=%h v=%b exp=%h v=1",
               tag, sz, sh, dir, res_o, valid_o, exp);
    end
  endtask

  task automatic idle_check();
    logic [127:0] prev = res_o;
    @(negedge clk_i);
    src_i = rnd128(); dst_i = rnd128(); shamt_i = 7'd3;
    @(negedge clk_i);
    checks++;
    if (res_o !== prev || valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 idle hold: res=%h v=%b exp=%h v=0", res_o, valid_o, prev);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    checks++;
    if (res_o !== '0 || valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: res=%h v=%b exp=0 v=0", res_o, valid_o);
    end
    rst_ni = 1'b1;

    for (int sz = 0; sz < 4; sz++) begin
      int es = 8 << sz;
      run({128{1'b1}}, '0, sz, 1, 1'b0, 1'b0, 1'b0, "R1 lane boundary left");
      run({128{1'b1}}, '0, sz, 1, 1'b1, 1'b0, 1'b0, "R1 lane boundary right");
      run(rnd128(), rnd128(), sz, es - 1, 1'b0, 1'b0, 1'b0, "R2 max left");
      run(rnd128(), rnd128(), sz, 1, 1'b1, 1'b0, 1'b0, "R3 min right");
      run(rnd128(), rnd128(), sz, es, 1'b1, 1'b0, 1'b0, "R4 full right");
      run(rnd128(), rnd128(), sz, 0, 1'b0, 1'b0, 1'b0, "R5 zero left");
      run(rnd128(), rnd128(), sz, es / 2, 1'b0, 1'b1, 1'b0, "R6 narrow left");
      run(rnd128(), rnd128(), sz, es / 2, 1'b1, 1'b1, 1'b0, "R6 narrow right");
      run(rnd128(), rnd128(), sz, 5, 1'b0, 1'b0, 1'b1, "R7 scalar left");
      run(rnd128(), rnd128(), sz, 64, 1'b1, 1'b0, 1'b1, "R7 R4 scalar full right");
      run(rnd128(), rnd128(), sz, es + 3, 1'b0, 1'b0, 1'b0, "R8 left beyond lane");
      run(rnd128(), rnd128(), sz, 127, 1'b1, 1'b0, 1'b0, "R8 right beyond lane");
      idle_check();
    end

    for (int n = 0; n < 400; n++) begin
      int sz = int'($urandom % 4);
      int es = 8 << sz;
      bit dir = 1'($urandom);
      bit nar = ($urandom % 4) == 0;
      bit sc  = ($urandom % 6) == 0;
      int lim = sc ? 64 : es;
      int sh = dir ? int'($urandom % lim) + 1 : int'($urandom % lim);
      if (($urandom % 10) == 0) sh = int'($urandom % 128);
      run(rnd128(), rnd128(), sz, sh, dir, nar, sc,
          dir ? "R3 random right" : "R2 random left");
      if ((n % 50) == 0) idle_check();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule